// File: doc/BRIEF.md
# HDB3 Receive Decoder with Line Code Violation Monitor

This block turns a dual-rail HDB3 line signal into a plain binary bit stream and watches that signal for coding errors. Each line clock, one positive-rail and one negative-rail pulse indication enter the block. A configuration input chooses whether the rails are captured on the rising or the falling edge of the clock. All logic after the capture runs on the rising edge.

Decoding tracks the polarity of the last pulse and counts the pulses seen since the last polarity violation. This tells a legal zero substitution apart from a corrupted one. A legal substitution is removed from the output. This includes the leading balancing pulse of a four-symbol substitution, which is cleared inside a four-stage output delay line before it leaves the block. An illegal violation, or a pulse on both rails at once, raises a one-cycle error pulse.

The errors feed a saturating event counter, which is read as two halves. They also feed a per-second accumulation counter, which is copied to a holding register on a one-second strobe. The accumulation counter also counts every run of three or more zeros on the line.

Top module: `hdb3_rx_decoder`

## Requirements
- R1: With `cfg_fall_edge`=0 the rails are captured on the rising clock edge. With `cfg_fall_edge`=1 they are captured on the falling edge just before it. A pulse held only for the first half of a cycle is seen in falling mode and missed in rising mode.
- R2: A capture with exactly one rail high is a pulse: positive polarity on `rail_pos`, negative on `rail_neg`. Unless R3 applies, a pulse decodes to 1 and a capture with no rail high decodes to 0. A symbol captured at rising edge k appears on `data_out` after edge k+4.
- R3: A pulse is a legal violation when all of the following hold: it has the same polarity as the previous single-rail pulse, the two captures before it carried no pulse, and an odd number of single-rail pulses arrived since the previous violation (or no violation has arrived since reset). A legal violation decodes to 0, as does the symbol captured three cycles before it, so both the three-zeros form and the balancing-pulse form come out as four zeros. It raises no error.
- R4: A same-polarity pulse that does not meet R3 is an error. It decodes to 1, removes nothing, and restarts the pulse parity count.
- R5: A capture with both rails high is an error and decodes to 1. It leaves the polarity reference and the parity count unchanged.
- R6: The first single-rail pulse after reset is never judged as a violation.
- R7: `lcv_pulse` is high for exactly the cycle after rising edge k+1 when the symbol captured at edge k is an error.
- R8: Each error increments a 16-bit event counter that saturates at 65535. The counter is read as `lcv_cnt_hi` (bits 15:8) and `lcv_cnt_lo` (bits 7:0).
- R9: Each run of consecutive no-pulse captures adds exactly one accumulation event, at its third capture, however long the run lasts.
- R10: The 16-bit accumulation counter adds one for each error and each R9 event, and saturates at 65535. When `sec_tick` is high at a rising edge, `acc_hold` takes the running count and the running count restarts from zero.
- R11: While reset is asserted, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_fall_edge | input | 1 | 1 selects falling-edge capture of the rails |
| rail_pos | input | 1 | Positive-polarity pulse indication |
| rail_neg | input | 1 | Negative-polarity pulse indication |
| sec_tick | input | 1 | One-second strobe that latches and clears the accumulation count |
| data_out | output | 1 | Decoded binary data, four clocks after capture |
| lcv_pulse | output | 1 | One-cycle line code violation indication |
| lcv_cnt_hi | output | 8 | Upper half of the error event counter |
| lcv_cnt_lo | output | 8 | Lower half of the error event counter |
| acc_hold | output | 16 | Accumulation count latched at the last one-second strobe |

## Verification
The bench drives full encoded streams that are rich in four-zero runs, in both capture modes. A design that forgets to clear the buffered balancing pulse would emit stray ones, and one that checks parity on the first violation after reset would flag clean traffic. Directed patterns place a violation after an even pulse count, after a pulse that is too recent, and after a both-rail capture; a wrong parity or polarity rule shows up as a missing or extra error pulse. Half-cycle pulses expose a swapped edge select. Zero runs of several lengths expose per-cycle rather than per-run counting, and long error bursts expose counters that wrap or a half split on the wrong bit.

// File: rtl/hdb3_rx_pkg.sv
package hdb3_rx_pkg;

  // Length of one zero-substitution group; also the output latency.
  localparam int SUB_LEN = 4;

  // Rail pair after capture: bit 0 = positive rail, bit 1 = negative rail.
  typedef enum logic [1:0] {
    SYM_NONE = 2'b00,
    SYM_POS  = 2'b01,
    SYM_NEG  = 2'b10,
    SYM_BOTH = 2'b11
  } sym_e;

  function automatic sym_e rails_to_sym(input logic pos, input logic neg);
    return sym_e'({neg, pos});
  endfunction

endpackage

// File: rtl/hdb3_rail_sampler.sv
module hdb3_rail_sampler
  import hdb3_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fall_sel,
  input  logic pos_i,
  input  logic neg_i,
  output sym_e sym_o
);

  logic [1:0] fall_cap_q;
  sym_e       sym_d;
  sym_e       sym_q;

  // Falling-edge capture stage, used only when fall_sel is set.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_cap_q <= 2'b00;
    end else begin
      fall_cap_q <= {neg_i, pos_i};
    end
  end

  always_comb begin
    if (fall_sel) begin
      sym_d = rails_to_sym(fall_cap_q[0], fall_cap_q[1]);
    end else begin
      sym_d = rails_to_sym(pos_i, neg_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_q <= SYM_NONE;
    end else begin
      sym_q <= sym_d;
    end
  end

  assign sym_o = sym_q;

endmodule

// File: rtl/hdb3_line_checker.sv
module hdb3_line_checker
  import hdb3_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  sym_e sym_i,
  output logic bit_o,
  output logic strip_o,
  output logic lcv_o,
  output logic exz_o
);

  logic       last_pos_q, last_pos_d;
  logic       ref_ok_q,   ref_ok_d;
  logic       v_seen_q,   v_seen_d;
  logic       par_q,      par_d;
  logic [1:0] hist_q,     hist_d;
  logic [1:0] zrun_q,     zrun_d;
  logic       lcv_q,      lcv_d;
  logic       exz_q,      exz_d;

  logic any_pulse;
  logic one_rail;
  logic pulse_pos;
  logic same_pol;
  logic quiet2;
  logic par_good;
  logic v_legal;
  logic v_illegal;

  // Classification of the current symbol.
  always_comb begin
    any_pulse = (sym_i != SYM_NONE);
    one_rail  = (sym_i == SYM_POS) || (sym_i == SYM_NEG);
    pulse_pos = (sym_i == SYM_POS);
    same_pol  = ref_ok_q && one_rail && (pulse_pos == last_pos_q);
    quiet2    = (hist_q == 2'b00);
    par_good  = !v_seen_q || par_q;
    v_legal   = same_pol && quiet2 && par_good;
    v_illegal = same_pol && !v_legal;
  end

  assign bit_o   = any_pulse && !v_legal;
  assign strip_o = v_legal;

  // Next-state logic.
  always_comb begin
    last_pos_d = last_pos_q;
    ref_ok_d   = ref_ok_q;
    v_seen_d   = v_seen_q;
    par_d      = par_q;
    if (one_rail) begin
      last_pos_d = pulse_pos;
      ref_ok_d   = 1'b1;
      if (same_pol) begin
        par_d    = 1'b0;
        v_seen_d = 1'b1;
      end else begin
        par_d    = ~par_q;
      end
    end
    hist_d = {hist_q[0], any_pulse};
    if (any_pulse) begin
      zrun_d = 2'd0;
    end else if (zrun_q != 2'd3) begin
      zrun_d = zrun_q + 2'd1;
    end else begin
      zrun_d = zrun_q;
    end
    lcv_d = v_illegal || (sym_i == SYM_BOTH);
    exz_d = !any_pulse && (zrun_q == 2'd2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_pos_q <= 1'b0;
      ref_ok_q   <= 1'b0;
      v_seen_q   <= 1'b0;
      par_q      <= 1'b0;
      hist_q     <= 2'b00;
      zrun_q     <= 2'd0;
      lcv_q      <= 1'b0;
      exz_q      <= 1'b0;
    end else begin
      last_pos_q <= last_pos_d;
      ref_ok_q   <= ref_ok_d;
      v_seen_q   <= v_seen_d;
      par_q      <= par_d;
      hist_q     <= hist_d;
      zrun_q     <= zrun_d;
      lcv_q      <= lcv_d;
      exz_q      <= exz_d;
    end
  end

  assign lcv_o = lcv_q;
  assign exz_o = exz_q;

  p_both_rail_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_i == SYM_BOTH) |=> lcv_o);

  p_first_pulse_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_ok_q && one_rail) |=> !lcv_o);

  p_zero_run_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exz_o |=> !exz_o);

endmodule

// File: rtl/hdb3_zero_strip.sv
module hdb3_zero_strip
  import hdb3_rx_pkg::*;
#(
  parameter int DEPTH = SUB_LEN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_i,
  input  logic clr_i,
  output logic bit_o
);

  // Stage whose input carries the symbol captured SUB_LEN-1 cycles earlier.
  localparam int CLR_STAGE = SUB_LEN - 1;

  logic [DEPTH-1:0] stage_q;
  logic [DEPTH-1:0] stage_d;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign stage_d[g] = bit_i;
    end else if (g == CLR_STAGE) begin : g_clear
      assign stage_d[g] = stage_q[g-1] & ~clr_i;
    end else begin : g_pass
      assign stage_d[g] = stage_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign bit_o = stage_q[DEPTH-1];

  p_strip_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !stage_q[CLR_STAGE]);

endmodule

// File: rtl/hdb3_err_counters.sv
module hdb3_err_counters #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lcv_i,
  input  logic             exz_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] lcv_cnt_o,
  output logic [CNT_W-1:0] acc_hold_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] ev_q,   ev_d;
  logic             ev_en;
  logic [CNT_W-1:0] acc_q,  acc_d;
  logic             acc_en;
  logic [CNT_W-1:0] hold_q, hold_d;
  logic             hold_en;
  logic             acc_ev;

  always_comb begin
    ev_en   = lcv_i;
    ev_d    = sat_inc(ev_q);
    acc_ev  = lcv_i || exz_i;
    hold_en = tick_i;
    hold_d  = acc_q;
    if (tick_i) begin
      acc_en = 1'b1;
      acc_d  = acc_ev ? CNT_W'(1) : '0;
    end else begin
      acc_en = acc_ev;
      acc_d  = sat_inc(acc_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q   <= '0;
      acc_q  <= '0;
      hold_q <= '0;
    end else begin
      if (ev_en)   ev_q   <= ev_d;
      if (acc_en)  acc_q  <= acc_d;
      if (hold_en) hold_q <= hold_d;
    end
  end

  assign lcv_cnt_o  = ev_q;
  assign acc_hold_o = hold_q;

  p_cnt_monotonic_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ev_q >= $past(ev_q)));

  p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lcv_i && ev_q != CNT_MAX) |=> (ev_q == $past(ev_q) + CNT_W'(1)));

  p_hold_only_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(hold_q));

endmodule

// File: rtl/hdb3_rx_decoder.sv
module hdb3_rx_decoder
  import hdb3_rx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_fall_edge,
  input  logic               rail_pos,
  input  logic               rail_neg,
  input  logic               sec_tick,
  output logic               data_out,
  output logic               lcv_pulse,
  output logic [CNT_W/2-1:0] lcv_cnt_hi,
  output logic [CNT_W/2-1:0] lcv_cnt_lo,
  output logic [CNT_W-1:0]   acc_hold
);

  localparam int HALF_W = CNT_W / 2;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  sym_e             sym;
  logic             dec_bit;
  logic             strip;
  logic             lcv;
  logic             exz;
  logic [CNT_W-1:0] lcv_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  hdb3_rail_sampler u_sampler (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .fall_sel (cfg_fall_edge),
    .pos_i    (rail_pos),
    .neg_i    (rail_neg),
    .sym_o    (sym)
  );

  hdb3_line_checker u_checker (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .sym_i   (sym),
    .bit_o   (dec_bit),
    .strip_o (strip),
    .lcv_o   (lcv),
    .exz_o   (exz)
  );

  hdb3_zero_strip #(.DEPTH(SUB_LEN)) u_strip (
    .clk   (clk),
    .rst_n (rst_int_n),
    .bit_i (dec_bit),
    .clr_i (strip),
    .bit_o (data_out)
  );

  hdb3_err_counters #(.CNT_W(CNT_W)) u_counters (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .lcv_i      (lcv),
    .exz_i      (exz),
    .tick_i     (sec_tick),
    .lcv_cnt_o  (lcv_cnt),
    .acc_hold_o (acc_hold)
  );

  assign lcv_pulse  = lcv;
  assign lcv_cnt_hi = lcv_cnt[CNT_W-1:HALF_W];
  assign lcv_cnt_lo = lcv_cnt[HALF_W-1:0];

endmodule

// File: tb/hdb3_rx_decoder_bench.sv
module hdb3_rx_decoder_bench;

  localparam int CNT_W = 16;
  localparam int MAXC  = (1 << CNT_W) - 1;
  localparam int NB    = 400;

  logic        clk;
  logic        rst_n;
  logic        cfg_fall_edge;
  logic        rail_pos;
  logic        rail_neg;
  logic        sec_tick;
  logic        data_out;
  logic        lcv_pulse;
  logic [7:0]  lcv_cnt_hi;
  logic [7:0]  lcv_cnt_lo;
  logic [15:0] acc_hold;

  hdb3_rx_decoder #(.CNT_W(CNT_W)) u_hdb3_rx_decoder (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_fall_edge (cfg_fall_edge),
    .rail_pos      (rail_pos),
    .rail_neg      (rail_neg),
    .sec_tick      (sec_tick),
    .data_out      (data_out),
    .lcv_pulse     (lcv_pulse),
    .lcv_cnt_hi    (lcv_cnt_hi),
    .lcv_cnt_lo    (lcv_cnt_lo),
    .acc_hold      (acc_hold)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int    n_chk;
  int    n_fail;
  string cur;

  // Reference model state.
  logic [3:0] edh;
  logic       el_prev;
  int         zr;
  int         exp_acc;
  int         exp_hold;
  int         exp_lcv;

  // Encoded stream buffers.
  bit sd [NB];
  bit sp [NB];
  bit sn [NB];

  function automatic int sat(input int v);
    return (v > MAXC) ? MAXC : v;
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0d expected=%0d", cur, what, act, expv);
    end
  endtask

  // One capture cycle; called at posedge+1, returns at the next posedge+1.
  task automatic step(input bit p, input bit n, input bit ed, input bit el,
                      input bit tick, input bit half);
    bit seen;
    bit ev;
    rail_pos = p;
    rail_neg = n;
    sec_tick = tick;
    if (half) begin
      #5;
      rail_pos = 1'b0;
      rail_neg = 1'b0;
    end
    @(posedge clk);
    #1;
    chk(data_out == edh[3], "data_out four cycles later (R2)", int'(data_out), int'(edh[3]));
    chk(lcv_pulse == el_prev, "lcv_pulse one cycle later (R7)", int'(lcv_pulse), int'(el_prev));
    edh     = {edh[2:0], ed};
    el_prev = el;
    seen = half ? (cfg_fall_edge && (p || n)) : (p || n);
    ev   = 1'b0;
    if (seen) begin
      zr = 0;
    end else begin
      if (zr == 2) ev = 1'b1;
      if (zr < 3) zr++;
    end
    exp_lcv = sat(exp_lcv + int'(el));
    if (tick) begin
      exp_hold = exp_acc;
      exp_acc  = 0;
    end else begin
      exp_acc = sat(exp_acc + int'(ev) + int'(el));
    end
    sec_tick = 1'b0;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  // Settle, strobe, then compare the latched and event counts (R8, R10).
  task automatic acc_check();
    idle(6);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    idle(2);
    chk(int'(acc_hold) == exp_hold, "acc_hold after strobe (R10)", int'(acc_hold), exp_hold);
    chk(int'(lcv_cnt_hi) == (exp_lcv >> 8), "lcv_cnt_hi (R8)", int'(lcv_cnt_hi), exp_lcv >> 8);
    chk(int'(lcv_cnt_lo) == (exp_lcv & 255), "lcv_cnt_lo (R8)", int'(lcv_cnt_lo), exp_lcv & 255);
  endtask

  task automatic do_reset(input bit fall, input bit check_r11);
    @(posedge clk);
    #1;
    rst_n         = 1'b0;
    cfg_fall_edge = fall;
    rail_pos      = 1'b0;
    rail_neg      = 1'b0;
    sec_tick      = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    if (check_r11) begin
      chk(data_out == 1'b0, "R11 data_out in reset", int'(data_out), 0);
      chk(lcv_pulse == 1'b0, "R11 lcv_pulse in reset", int'(lcv_pulse), 0);
      chk(lcv_cnt_hi == 8'd0, "R11 lcv_cnt_hi in reset", int'(lcv_cnt_hi), 0);
      chk(lcv_cnt_lo == 8'd0, "R11 lcv_cnt_lo in reset", int'(lcv_cnt_lo), 0);
      chk(acc_hold == 16'd0, "R11 acc_hold in reset", int'(acc_hold), 0);
    end
    rst_n = 1'b1;
    repeat (8) @(posedge clk);
    #1;
    edh      = 4'b0000;
    el_prev  = 1'b0;
    zr       = 3;
    exp_acc  = 0;
    exp_hold = 0;
    exp_lcv  = 0;
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    exp_acc  = 0;
  endtask

  // Build a clean HDB3 stream from sparse pseudo-random data.
  task automatic build_stream(input logic [15:0] seed);
    logic [15:0] lf;
    bit last;
    bit par;
    int i;
    lf = seed;
    for (int j = 0; j < NB; j++) begin
      lf    = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      sd[j] = (lf[1:0] == 2'b00);
      sp[j] = 1'b0;
      sn[j] = 1'b0;
    end
    last = 1'b0;
    par  = 1'b0;
    i    = 0;
    while (i < NB) begin
      if (i + 3 < NB && !sd[i] && !sd[i+1] && !sd[i+2] && !sd[i+3]) begin
        if (!par) begin
          last  = ~last;
          sp[i] = last;
          sn[i] = ~last;
        end
        sp[i+3] = last;
        sn[i+3] = ~last;
        par = 1'b0;
        i   = i + 4;
      end else if (sd[i]) begin
        last  = ~last;
        sp[i] = last;
        sn[i] = ~last;
        par   = ~par;
        i++;
      end else begin
        i++;
      end
    end
  endtask

  task automatic run_stream();
    for (int j = 0; j < NB; j++) step(sp[j], sn[j], sd[j], 1'b0, 1'b0, 1'b0);
    idle(4);
  endtask

  initial begin
    n_chk         = 0;
    n_fail        = 0;
    rst_n         = 1'b0;
    cfg_fall_edge = 1'b0;
    rail_pos      = 1'b0;
    rail_neg      = 1'b0;
    sec_tick      = 1'b0;
    edh           = 4'b0000;
    el_prev       = 1'b0;

    cur = "R11 reset";
    do_reset(1'b0, 1'b1);

    // R2 / R3: clean encoded traffic, rising capture.
    cur = "R2 R3 stream rising";
    build_stream(16'hACE1);
    run_stream();
    acc_check();

    // R1: same traffic class captured on the falling edge.
    cur = "R1 stream falling";
    do_reset(1'b1, 1'b0);
    build_stream(16'h5A3C);
    run_stream();
    acc_check();

    // R1: half-cycle pulse is seen only in falling mode.
    cur = "R1 half pulse falling";
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    idle(5);
    cur = "R1 half pulse rising";
    do_reset(1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    idle(5);
    acc_check();

    // R6: the very first pulse after reset is plain data.
    cur = "R6 first pulse";
    do_reset(1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    idle(5);
    acc_check();

    // R4: same polarity right after a pulse.
    cur = "R4 adjacent violation";
    do_reset(1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    idle(5);
    acc_check();

    // R3: balancing-pulse form, then three-zeros form, both stripped.
    cur = "R3 substitutions";
    do_reset(1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    // R4: even pulse count since the last violation.
    cur = "R4 parity violation";
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    idle(5);
    acc_check();

    // R5: both rails flag an error and keep the polarity reference.
    cur = "R5 both rails";
    do_reset(1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    idle(5);
    acc_check();

    // R9: runs of two, three and five zeros.
    cur = "R9 zero runs";
    do_reset(1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    idle(2);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    idle(3);
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    idle(5);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    acc_check();
    chk(int'(acc_hold) == 3, "R9 run events in hold", int'(acc_hold), 3);

    // R10: a quiet second latches zero.
    cur = "R10 cleared interval";
    acc_check();

    // R8: split readout, then saturation of both counters.
    cur = "R8 split";
    do_reset(1'b0, 1'b0);
    for (int j = 0; j < 300; j++) step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    acc_check();
    cur = "R8 R10 saturation";
    for (int j = 0; j < 65600; j++) step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    acc_check();
    chk(int'(acc_hold) == MAXC, "R10 accumulation saturates", int'(acc_hold), MAXC);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule